// File: doc/BRIEF.md
# Cartesian Gate-Array Fitness Evaluator

This block scores a candidate logic circuit against a fixed target function. The candidate is a flat genotype word that describes a feed-forward grid of small logic cells. Each cell has three input connection genes and one function gene. Further genes choose which signals drive the circuit's outputs. A single-cycle start pulse loads the genotype. The block then sweeps every input combination of the target. For each combination it evaluates the cells one by one in label order and compares the selected outputs bit by bit with the target. When the last combination has been compared, it reports the number of matching bits through a one-cycle done pulse and a held fitness value.

The target is an unsigned multiplier: AW bits by AW bits, giving 2·AW outputs. With the default AW = 3 there are 64 input rows and 6 output bits per row, so a perfect circuit scores 384. The grid size (ROWS × COLS) and the levels-back reach LB are parameters.

Top module: `cgp_fitness_eval`

## Requirements
- R1: While reset is high and after it is released, `done` is 0 and `fitness` is 0 until the first evaluation completes.
- R2: Signal labels are assigned as follows. Labels 0..N_IN-1 are the circuit inputs, and input i carries bit i of the row index. Row bits [AW-1:0] form the multiplicand and bits [2·AW-1:AW] form the multiplier. The cell in column c and row r carries label N_IN + c·ROWS + r.
- R3: Gene layout. Cell k occupies genotype bits [k·CG +: CG], where CG = 3·LW + 2. Its source labels sit at offsets 0, LW and 2·LW, each LW bits wide, and its 2-bit function sits at offset 3·LW. The gene for output j occupies bits [NCELL·CG + j·LW +: LW].
- R4: Function codes, with inputs (a, b, s) taken from the three sources in order: 0 gives a AND b; 1 gives a AND NOT b; 2 gives a XOR b; 3 is a 2:1 multiplexer that yields b when s is 1 and a when s is 0.
- R5: A cell source reads as 0 when it is not allowed. A circuit input is allowed only for cells in columns below LB. A cell output is allowed only when it comes from a strictly lower column that is at most LB columns back. Labels at or above NLAB are never allowed.
- R6: An output gene whose label is below NLAB selects that signal, with no column restriction. A label at or above NLAB drives the output to 0.
- R7: `fitness` is the number of output bits equal to the matching bit of the 2·AW-bit product, summed over all 2^N_IN input rows.
- R8: `done` is high for exactly one cycle. It rises NROW·(NCELL+1) clock edges after the edge that samples `start`.
- R9: A start accepted while idle clears `fitness` to 0 at the sampling edge. `fitness` then holds its final value from `done` until the next accepted start.
- R10: A `start` pulse during an evaluation is ignored. The running evaluation keeps its genotype and its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an evaluation; sampled only while idle |
| genotype | input | GW | Genotype word, captured on an accepted start |
| done | output | 1 | One-cycle pulse when scoring completes |
| fitness | output | FW | Count of matching output bits |

## Verification
Each row costs NCELL cell cycles plus one compare cycle. The final score and `done` therefore appear 1088 edges after the start-sampling edge with the defaults. The bench counts falling edges from the first one after that edge and requires the count to equal NROW·(NCELL+1). It reads `fitness` at that same falling edge. The cleared score is checked at the falling edge right after the start edge, before the first compare cycle can add to it. Holding of the result is checked over twenty idle cycles after `done`, and `done` must already be low one cycle after it rises.

// File: rtl/cgp_eval_pkg.sv
package cgp_eval_pkg;

    typedef enum logic [1:0] {
        FN_AND  = 2'd0,
        FN_ANDN = 2'd1,
        FN_XOR  = 2'd2,
        FN_MUX  = 2'd3
    } cell_fn_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CELL = 2'd1,
        PH_CMP  = 2'd2
    } eval_phase_e;

    typedef struct packed {
        logic a;
        logic b;
        logic s;
    } cell_pins_t;

    function automatic logic apply_fn(cell_fn_e f, cell_pins_t p);
        logic y;
        unique case (f)
            FN_AND:  y = p.a & p.b;
            FN_ANDN: y = p.a & ~p.b;
            FN_XOR:  y = p.a ^ p.b;
            default: y = p.s ? p.b : p.a;
        endcase
        return y;
    endfunction

endpackage

// File: rtl/cgp_gate_cell.sv
module cgp_gate_cell
    import cgp_eval_pkg::*;
#(
    parameter int N_IN  = 6,
    parameter int ROWS  = 2,
    parameter int LB    = 3,
    parameter int NLAB  = 22,
    parameter int LW    = 5,
    parameter int CW    = 4
) (
    input  logic [NLAB-1:0]    vals,
    input  logic [CW-1:0]      cell_idx,
    input  logic [3*LW+1:0]    gene,
    output logic               y
);
    logic [2:0] pin;
    cell_pins_t pins;

    always_comb begin
        int col;
        int lab;
        int scol;
        logic ok;
        col = int'(cell_idx) / ROWS;
        for (int s = 0; s < 3; s++) begin
            lab  = int'(gene[s*LW +: LW]);
            scol = 0;
            ok   = 1'b0;
            if (lab < N_IN) begin
                ok = (col < LB);
            end else if (lab < NLAB) begin
                scol = (lab - N_IN) / ROWS;
                ok   = (scol < col) && (scol >= col - LB);
            end
            pin[s] = ok ? vals[gene[s*LW +: LW]] : 1'b0;
        end
    end

    assign pins = '{a: pin[0], b: pin[1], s: pin[2]};
    assign y    = apply_fn(cell_fn_e'(gene[3*LW +: 2]), pins);

endmodule

// File: rtl/cgp_row_match.sv
module cgp_row_match #(
    parameter int N_OUT = 6,
    parameter int MW    = 3
) (
    input  logic [N_OUT-1:0] got,
    input  logic [N_OUT-1:0] want,
    output logic [MW-1:0]    hits
);
    always_comb begin
        hits = '0;
        for (int j = 0; j < N_OUT; j++) begin
            if (got[j] == want[j]) hits = hits + MW'(1);
        end
    end
endmodule

// File: rtl/cgp_fitness_eval.sv
module cgp_fitness_eval
    import cgp_eval_pkg::*;
#(
    parameter int AW   = 3,
    parameter int ROWS = 2,
    parameter int COLS = 8,
    parameter int LB   = 3,
    localparam int N_IN  = 2 * AW,
    localparam int N_OUT = 2 * AW,
    localparam int NCELL = ROWS * COLS,
    localparam int NLAB  = N_IN + NCELL,
    localparam int LW    = $clog2(NLAB),
    localparam int CG    = 3 * LW + 2,
    localparam int GW    = NCELL * CG + N_OUT * LW,
    localparam int NROW  = 1 << N_IN,
    localparam int FMAX  = N_OUT * NROW,
    localparam int FW    = $clog2(FMAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [GW-1:0] genotype,
    output logic          done,
    output logic [FW-1:0] fitness
);
    localparam int CW = (NCELL > 1) ? $clog2(NCELL) : 1;
    localparam int MW = $clog2(N_OUT + 1);

    eval_phase_e      phase_q;
    logic [GW-1:0]    geno_q;
    logic [CW-1:0]    cell_q;
    logic [N_IN-1:0]  row_q;
    logic [NCELL-1:0] cellv_q;
    logic [FW-1:0]    fit_q;
    logic             done_q;

    logic [NLAB-1:0]  vals;
    logic [CG-1:0]    cur_gene;
    logic             cell_y;
    logic [N_OUT-1:0] got;
    logic [N_OUT-1:0] want;
    logic [MW-1:0]    hits;

    assign vals     = {cellv_q, row_q};
    assign cur_gene = geno_q[int'(cell_q)*CG +: CG];

    cgp_gate_cell #(
        .N_IN(N_IN), .ROWS(ROWS), .LB(LB), .NLAB(NLAB), .LW(LW), .CW(CW)
    ) u_cell (
        .vals(vals), .cell_idx(cell_q), .gene(cur_gene), .y(cell_y)
    );

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        logic [LW-1:0] olab;
        assign olab   = geno_q[NCELL*CG + j*LW +: LW];
        assign got[j] = (int'(olab) < NLAB) ? vals[olab] : 1'b0;
    end

    assign want = {{AW{1'b0}}, row_q[AW-1:0]} * {{AW{1'b0}}, row_q[N_IN-1:AW]};

    cgp_row_match #(.N_OUT(N_OUT), .MW(MW)) u_match (
        .got(got), .want(want), .hits(hits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            geno_q  <= '0;
            cell_q  <= '0;
            row_q   <= '0;
            cellv_q <= '0;
            fit_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        geno_q  <= genotype;
                        fit_q   <= '0;
                        row_q   <= '0;
                        cell_q  <= '0;
                        cellv_q <= '0;
                        phase_q <= PH_CELL;
                    end
                end
                PH_CELL: begin
                    cellv_q[cell_q] <= cell_y;
                    if (cell_q == CW'(NCELL - 1)) phase_q <= PH_CMP;
                    else cell_q <= cell_q + CW'(1);
                end
                default: begin
                    fit_q  <= fit_q + FW'(hits);
                    cell_q <= '0;
                    if (row_q == '1) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        row_q   <= row_q + N_IN'(1);
                        phase_q <= PH_CELL;
                    end
                end
            endcase
        end
    end

    assign done    = done_q;
    assign fitness = fit_q;

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R8
    done_after_cmp_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(phase_q) == PH_CMP);

    // R9
    fit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && !start) |=> $stable(fit_q));

    // R7
    fit_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fit_q <= FW'(FMAX));

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE) |=> $stable(geno_q));

    // R2
    cell_order_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_CELL && cell_q != CW'(NCELL - 1)) |=> cell_q == $past(cell_q) + CW'(1));

endmodule

// File: tb/cgp_fitness_eval_bench.sv
module cgp_fitness_eval_bench;
    localparam int CLK_P = 10;
    localparam int AW    = 3;
    localparam int ROWS  = 2;
    localparam int COLS  = 8;
    localparam int LB    = 3;
    localparam int N_IN  = 2 * AW;
    localparam int N_OUT = 2 * AW;
    localparam int NCELL = ROWS * COLS;
    localparam int NLAB  = N_IN + NCELL;
    localparam int LW    = $clog2(NLAB);
    localparam int CG    = 3 * LW + 2;
    localparam int GW    = NCELL * CG + N_OUT * LW;
    localparam int NROW  = 1 << N_IN;
    localparam int FW    = $clog2(N_OUT * NROW + 1);
    localparam int BAD   = (1 << LW) - 1;
    localparam int RUNLEN = NROW * (NCELL + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [GW-1:0] geno_in = '0;
    logic          done;
    logic [FW-1:0] fitness;
    logic [GW-1:0] g;
    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] rs = 32'h1234_5678;

    cgp_fitness_eval #(.AW(AW), .ROWS(ROWS), .COLS(COLS), .LB(LB)) u_cgp_fitness_eval (
        .clk(clk), .rst(rst), .start(start), .genotype(geno_in),
        .done(done), .fitness(fitness)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rnd(input int m);
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return int'(rs % 32'(m));
    endfunction

    task automatic put_cell(input int k, input int s0, input int s1, input int s2, input int fn);
        g[k*CG +: LW]        = LW'(s0);
        g[k*CG + LW +: LW]   = LW'(s1);
        g[k*CG + 2*LW +: LW] = LW'(s2);
        g[k*CG + 3*LW +: 2]  = 2'(fn);
    endtask

    task automatic put_out(input int j, input int lab);
        g[NCELL*CG + j*LW +: LW] = LW'(lab);
    endtask

    task automatic blank();
        g = '0;
        for (int j = 0; j < N_OUT; j++) put_out(j, BAD);
    endtask

    function automatic int prod(input int row);
        return (row % (1 << AW)) * (row >> AW);
    endfunction

    // Independent model of R2..R7
    function automatic int ref_fit(input logic [GW-1:0] gg);
        int fit = 0;
        for (int row = 0; row < NROW; row++) begin
            logic [NLAB-1:0] v;
            int p;
            v = '0;
            for (int i = 0; i < N_IN; i++) v[i] = row[i];
            for (int k = 0; k < NCELL; k++) begin
                logic [2:0] x;
                int col, fn;
                col = k / ROWS;
                for (int s = 0; s < 3; s++) begin
                    int lab;
                    lab = int'(gg[k*CG + s*LW +: LW]);
                    x[s] = 1'b0;
                    if (lab < N_IN) begin
                        if (col < LB) x[s] = v[lab];
                    end else if (lab < NLAB) begin
                        if ((lab - N_IN) / ROWS < col && (lab - N_IN) / ROWS >= col - LB) x[s] = v[lab];
                    end
                end
                fn = int'(gg[k*CG + 3*LW +: 2]);
                case (fn)
                    0: v[N_IN+k] = x[0] & x[1];
                    1: v[N_IN+k] = x[0] & ~x[1];
                    2: v[N_IN+k] = x[0] ^ x[1];
                    default: v[N_IN+k] = x[2] ? x[1] : x[0];
                endcase
            end
            p = prod(row);
            for (int j = 0; j < N_OUT; j++) begin
                int lab;
                logic o;
                lab = int'(gg[NCELL*CG + j*LW +: LW]);
                o = (lab < NLAB) ? v[lab] : 1'b0;
                if (o == p[j]) fit++;
            end
        end
        return fit;
    endfunction

    // Score when out0 = f(row) and other outputs tie to 0
    function automatic int one_bit_fit(input int sel);
        int fit = 0;
        for (int row = 0; row < NROW; row++) begin
            int p;
            logic x0, x1, x2, f;
            p = prod(row);
            x0 = row[0]; x1 = row[1]; x2 = row[2];
            case (sel)
                0: f = x0 & x1;
                1: f = x0 & ~x1;
                2: f = x0 ^ x1;
                3: f = x2 ? x1 : x0;
                4: f = x1;
                5: f = (x0 & x1) ^ x2;
                default: f = 1'b0;
            endcase
            if (f == p[0]) fit++;
            for (int j = 1; j < N_OUT; j++) if (p[j] == 0) fit++;
        end
        return fit;
    endfunction

    task automatic run_eval(input logic [GW-1:0] gg, output int fit, output int cyc, output int fit0);
        @(negedge clk);
        geno_in = gg;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        fit0 = int'(fitness);
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        fit = int'(fitness);
    endtask

    initial begin
        int fit, cyc, f0, zf, idf, fb;
        logic [GW-1:0] ga;

        zf = 0;
        idf = 0;
        for (int row = 0; row < NROW; row++)
            for (int j = 0; j < N_OUT; j++) begin
                if (prod(row) % (1 << (j + 1)) < (1 << j)) zf++;
                if (row[j] == prod(row) % (1 << (j + 1)) / (1 << j)) idf++;
            end

        repeat (3) @(negedge clk);
        // R1
        chk("R1 done in reset", int'(done), 0);
        chk("R1 fitness in reset", int'(fitness), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 done after reset", int'(done), 0);
        chk("R1 fitness after reset", int'(fitness), 0);

        // R6 R7: all outputs on out-of-range labels
        blank();
        run_eval(g, fit, cyc, f0);
        chk("R6 out-of-range outputs", fit, zf);
        chk("R8 latency", cyc, RUNLEN);

        // R2 R6: outputs wired to inputs
        blank();
        for (int j = 0; j < N_OUT; j++) put_out(j, j);
        run_eval(g, fit, cyc, f0);
        chk("R2 input labels on outputs", fit, idf);

        // R4: each function code on cell 0
        for (int fn = 0; fn < 4; fn++) begin
            blank();
            put_cell(0, 0, 1, 2, fn);
            put_out(0, N_IN);
            run_eval(g, fit, cyc, f0);
            chk($sformatf("R4 function code %0d", fn), fit, one_bit_fit(fn));
        end

        // R5: input beyond levels-back (cell 6, column 3)
        blank();
        put_cell(6, 0, 1, 0, 2);
        put_out(0, N_IN + 6);
        run_eval(g, fit, cyc, f0);
        chk("R5 input beyond reach reads 0", fit, zf);

        // R5: input within reach (cell 4, column 2)
        blank();
        put_cell(4, 0, 1, 0, 2);
        put_out(0, N_IN + 4);
        run_eval(g, fit, cyc, f0);
        chk("R5 input within reach", fit, one_bit_fit(2));

        // R5: same-column source reads 0
        blank();
        put_cell(0, N_IN + 1, 1, 0, 2);
        put_out(0, N_IN);
        run_eval(g, fit, cyc, f0);
        chk("R5 same-column source", fit, one_bit_fit(4));

        // R2 R3: chain from column 0 into column 1
        blank();
        put_cell(0, 0, 1, 0, 0);
        put_cell(2, N_IN, 2, 0, 2);
        put_out(0, N_IN + 2);
        run_eval(g, fit, cyc, f0);
        chk("R3 chained cells", fit, one_bit_fit(5));

        // R7: pseudo-random genotypes
        for (int t = 0; t < 6; t++) begin
            g = '0;
            for (int k = 0; k < NCELL; k++)
                put_cell(k, rnd(NLAB), rnd(NLAB), rnd(NLAB), rnd(4));
            for (int j = 0; j < N_OUT; j++) put_out(j, rnd(NLAB + 2));
            run_eval(g, fit, cyc, f0);
            chk($sformatf("R7 random genotype %0d", t), fit, ref_fit(g));
        end

        // R10: start during evaluation ignored
        blank();
        ga = g;
        @(negedge clk);
        geno_in = ga;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R9: cleared at the sampling edge
        chk("R9 fitness cleared on start", int'(fitness), 0);
        repeat (99) @(negedge clk);
        for (int j = 0; j < N_OUT; j++) put_out(j, j);
        geno_in = g;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 100;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        chk("R10 busy start latency", cyc, RUNLEN);
        chk("R10 busy start ignored", int'(fitness), zf);
        fb = int'(fitness);

        // R8 R9: single pulse, held value
        @(negedge clk);
        chk("R8 done one cycle", int'(done), 0);
        repeat (20) @(negedge clk);
        chk("R9 fitness held", int'(fitness), fb);

        summary();
        $finish;
    end
endmodule